// File: doc/BRIEF.md
# Attribute Register Port with Index/Data Toggle

This block is a bank of 8-bit attribute registers reached through a single write port. One toggle bit decides how each write on that port is taken. In the index phase the byte becomes the register index. In the data phase the byte is stored into the register that the index selects. Every write flips the phase.

There is a separate strobe for reading back the stored index and one for reading the selected register. A third strobe reads a status byte that arrives on an input bus. That status read also forces the toggle back to the index phase, so software can always reach a known phase before it starts an index/data pair.

The register count is a parameter. Only the low bits of the stored index select a register. The next bit up is brought out as a flag. Every read returns its byte, with a valid pulse, one cycle after the strobe.

Top module: `attr_port`

## Requirements
- R1: After synchronous reset the block is in the index phase (`data_phase` = 0), the stored index is 0x00, `flag_out` is 0 and `rd_valid` is 0.
- R2: A write in the index phase stores the whole byte as the index and moves the block to the data phase (`data_phase` = 1) on the next cycle.
- R3: A write in the data phase stores the byte into the register selected by index bits [4:0] and returns the block to the index phase. A later data read of that index returns the byte.
- R4: A status read returns the `stat_in` byte sampled with the strobe and forces the index phase on the next cycle. If a write arrives in the same cycle, the write is still taken according to the current phase, and the index phase follows.
- R5: An index read returns the full stored 8-bit index. Neither an index read nor a data read changes the phase.
- R6: `flag_out` equals bit 5 of the stored index. Index bits 7:5 take no part in register selection, so index 0x25 reaches the same register as 0x05.
- R7: When index bits [4:0] are not below the register count (21 by default), a data write changes no register and a data read returns 0x00.
- R8: `rd_valid` is 1 in exactly the cycle after any read strobe and 0 otherwise. When several read strobes coincide, the status read takes precedence over the data read, and the data read over the index read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Byte written to the shared port |
| idx_rd | input | 1 | Index read strobe |
| dat_rd | input | 1 | Register data read strobe |
| stat_rd | input | 1 | Status read strobe; also forces the index phase |
| stat_in | input | 8 | Status byte returned by a status read |
| rd_valid | output | 1 | Read result valid, one cycle after a strobe |
| rd_data | output | 8 | Read result |
| data_phase | output | 1 | 1 when the next write is taken as data |
| flag_out | output | 1 | Bit 5 of the stored index |

## Verification
Index/data pairs are written to registers at both ends of the range with alternating, all-ones and all-zeros bytes. This separates a correct phase toggle from a stuck or inverted one, and also catches a wrong register selection. Status reads are placed in the data phase, between writes and alongside a write, to show that the phase reset wins and that the concurrent write still lands. Indices with the upper bits set, and indices just past the register count, separate masking from full decoding and show that out-of-range writes are dropped. Coincident read strobes confirm the precedence order.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_INDEX = 2'd1,
    RK_DATA  = 2'd2,
    RK_STAT  = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/attr_phase.sv
module attr_phase
  import attr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  logic   stat_rd,
  input  logic   idx_rd,
  output phase_e phase,
  output logic   idx_we,
  output logic   reg_we
);
  phase_e phase_q;

  // Decode the current meaning of a write on the shared port.
  assign idx_we = wr_en && (phase_q == PH_INDEX);
  assign reg_we = wr_en && (phase_q == PH_DATA);
  assign phase  = phase_q;

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= PH_INDEX;
    else if (stat_rd) phase_q <= PH_INDEX;
    else if (wr_en)   phase_q <= (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
  end

  // R2: an index write leads to the data phase
  a_r2_to_data: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !stat_rd && phase_q == PH_INDEX) |=> (phase_q == PH_DATA));
  // R3: a data write leads back to the index phase
  a_r3_to_index: assert property (@(posedge clk) disable iff (rst)
    (wr_en && phase_q == PH_DATA) |=> (phase_q == PH_INDEX));
  // R4: a status read always forces the index phase
  a_r4_stat_clear: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (phase_q == PH_INDEX));
  // R5: reads other than status leave the phase alone
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (idx_rd && !wr_en && !stat_rd) |=> $stable(phase_q));
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile #(
  parameter int NUM_REGS = 21,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [SEL_W-1:0]  rsel,
  output logic [DATA_W-1:0] q
);
  localparam int SEL_SPAN = 1 << SEL_W;

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic w_ok, r_ok;

  // Pick the range check: a fully populated bank needs none.
  generate
    if (NUM_REGS >= SEL_SPAN) begin : g_full
      assign w_ok = 1'b1;
      assign r_ok = 1'b1;
    end else begin : g_part
      localparam logic [SEL_W:0] LIMIT = NUM_REGS[SEL_W:0];
      assign w_ok = ({1'b0, wsel} < LIMIT);
      assign r_ok = ({1'b0, rsel} < LIMIT);
    end
  endgenerate

  // Storage without reset so it can map onto block or distributed RAM.
  always_ff @(posedge clk) begin
    if (we && w_ok) mem[wsel] <= wdata;
  end

  // Registered read port; out-of-range selects read as zero.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= r_ok ? mem[rsel] : '0;
  end

  // R7: reads outside the bank return zero
  a_r7_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (re && !r_ok) |=> (q == '0));
endmodule

// File: rtl/attr_rdmux.sv
module attr_rdmux
  import attr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_rd,
  input  logic              dat_rd,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] idx_val,
  input  logic [DATA_W-1:0] stat_in,
  input  logic [DATA_W-1:0] reg_q,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  rd_kind_e          kind_q;
  logic [DATA_W-1:0] idx_cap, stat_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= RK_NONE;
      idx_cap  <= '0;
      stat_cap <= '0;
    end else begin
      if (stat_rd)     kind_q <= RK_STAT;
      else if (dat_rd) kind_q <= RK_DATA;
      else if (idx_rd) kind_q <= RK_INDEX;
      else             kind_q <= RK_NONE;
      if (idx_rd)  idx_cap  <= idx_val;
      if (stat_rd) stat_cap <= stat_in;
    end
  end

  // Selection among registered sources only; no extra cycle.
  always_comb begin
    unique case (kind_q)
      RK_INDEX: rd_data = idx_cap;
      RK_DATA:  rd_data = reg_q;
      RK_STAT:  rd_data = stat_cap;
      default:  rd_data = '0;
    endcase
  end

  assign rd_valid = (kind_q != RK_NONE);

  // R8: each strobe yields a valid one cycle later
  a_r8_valid: assert property (@(posedge clk) disable iff (rst)
    (idx_rd || dat_rd || stat_rd) |=> rd_valid);
  // R8: no valid without a strobe
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !(idx_rd || dat_rd || stat_rd) |=> !rd_valid);
  // R4: status read returns the sampled status byte
  a_r4_stat_data: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data == $past(stat_in)));
endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_pkg::*;
#(
  parameter int NUM_REGS = 21,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idx_rd,
  input  logic              dat_rd,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] stat_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_phase,
  output logic              flag_out
);
  localparam int FLAG_BIT = SEL_W;

  phase_e            phase;
  logic              idx_we, reg_we;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] reg_q;
  logic [SEL_W-1:0]  sel;

  attr_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .stat_rd (stat_rd),
    .idx_rd  (idx_rd),
    .phase   (phase),
    .idx_we  (idx_we),
    .reg_we  (reg_we)
  );

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_we) idx_q <= wr_data;
  end

  assign sel        = idx_q[SEL_W-1:0];
  assign flag_out   = idx_q[FLAG_BIT];
  assign data_phase = (phase == PH_DATA);

  attr_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wsel  (sel),
    .wdata (wr_data),
    .re    (dat_rd),
    .rsel  (sel),
    .q     (reg_q)
  );

  attr_rdmux #(
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .idx_rd   (idx_rd),
    .dat_rd   (dat_rd),
    .stat_rd  (stat_rd),
    .idx_val  (idx_q),
    .stat_in  (stat_in),
    .reg_q    (reg_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R6: the flag follows bit 5 of each index write
  a_r6_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !data_phase) |=> (flag_out == $past(wr_data[FLAG_BIT])));
  // R1: right after reset the block waits for an index
  a_r1_reset: assert property (@(posedge clk)
    $past(rst) |-> (!data_phase && !flag_out && !rd_valid));
endmodule

// File: tb/attr_port_tb.sv
module attr_port_tb;
  localparam int NUM = 21;

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0, idx_rd = 0, dat_rd = 0, stat_rd = 0;
  logic [7:0] wr_data = 0, stat_in = 0;
  logic       rd_valid, data_phase, flag_out;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_regs [32];
  logic [7:0] m_idx = 0;
  bit         m_ph  = 0;

  always #5 clk = ~clk;

  attr_port u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .idx_rd(idx_rd), .dat_rd(dat_rd), .stat_rd(stat_rd), .stat_in(stat_in),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .data_phase(data_phase), .flag_out(flag_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg();
    logic [4:0] s = m_idx[4:0];
    return (s < NUM) ? m_regs[s] : 8'h00;
  endfunction

  task automatic model_wr(input logic [7:0] b);
    if (!m_ph) begin m_idx = b; m_ph = 1; end
    else begin
      if (m_idx[4:0] < NUM) m_regs[m_idx[4:0]] = b;
      m_ph = 0;
    end
  endtask

  task automatic do_wr(input logic [7:0] b);
    wr_en = 1; wr_data = b;
    @(posedge clk); #1;
    wr_en = 0;
    model_wr(b);
  endtask

  task automatic do_rd(input bit ir, input bit dr, input bit sr,
                       input logic [7:0] st, output logic [7:0] got);
    idx_rd = ir; dat_rd = dr; stat_rd = sr; stat_in = st;
    @(posedge clk); #1;
    idx_rd = 0; dat_rd = 0; stat_rd = 0;
    chk("R8 valid after strobe", {7'd0, rd_valid}, 8'd1);
    got = rd_data;
    if (sr) m_ph = 0;
  endtask

  task automatic to_index();
    logic [7:0] g;
    if (m_ph) do_rd(0, 0, 1, 8'h00, g);
  endtask

  task automatic put(input logic [7:0] i, input logic [7:0] d);
    to_index();
    do_wr(i);
    do_wr(d);
  endtask

  task automatic get(input logic [7:0] i, output logic [7:0] got);
    to_index();
    do_wr(i);
    do_rd(0, 1, 0, 8'h00, got);
  endtask

  task automatic t_reset();
    logic [7:0] g;
    chk("R1 phase", {7'd0, data_phase}, 8'd0);
    chk("R1 flag", {7'd0, flag_out}, 8'd0);
    chk("R1 valid", {7'd0, rd_valid}, 8'd0);
    do_rd(1, 0, 0, 8'h00, g);
    chk("R1 index", g, 8'h00);
    @(posedge clk); #1;
    chk("R8 valid drops", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic t_pairs();
    logic [7:0] g;
    to_index();
    do_wr(8'h03);
    chk("R2 data phase", {7'd0, data_phase}, 8'd1);
    do_wr(8'hA5);
    chk("R3 index phase", {7'd0, data_phase}, 8'd0);
    put(8'h00, 8'hFF);
    put(8'h14, 8'h5A);
    put(8'h0A, 8'h00);
    get(8'h03, g); chk("R3 reg 3", g, exp_reg());
    get(8'h00, g); chk("R3 reg 0", g, exp_reg());
    get(8'h14, g); chk("R3 reg 20", g, exp_reg());
    get(8'h0A, g); chk("R3 reg 10", g, exp_reg());
    chk("R5 data read keeps phase", {7'd0, data_phase}, 8'd1);
  endtask

  task automatic t_index_read();
    logic [7:0] g;
    to_index();
    do_wr(8'hC7);
    do_rd(1, 0, 0, 8'h00, g);
    chk("R5 index value", g, 8'hC7);
    chk("R5 phase kept", {7'd0, data_phase}, 8'd1);
    do_wr(8'h3C);
    do_rd(1, 0, 0, 8'h00, g);
    chk("R5 phase kept idle", {7'd0, data_phase}, 8'd0);
  endtask

  task automatic t_status();
    logic [7:0] g;
    to_index();
    do_wr(8'h02);
    do_rd(0, 0, 1, 8'h96, g);
    chk("R4 status byte", g, 8'h96);
    chk("R4 index phase", {7'd0, data_phase}, 8'd0);
    do_wr(8'h04);
    chk("R4 next write is index", {7'd0, data_phase}, 8'd1);
    do_rd(1, 0, 0, 8'h00, g);
    chk("R4 index took byte", g, 8'h04);
    // write and status read together in the data phase
    wr_en = 1; wr_data = 8'h77; stat_rd = 1; stat_in = 8'h11;
    @(posedge clk); #1;
    wr_en = 0; stat_rd = 0;
    model_wr(8'h77); m_ph = 0;
    chk("R4 concurrent status", rd_data, 8'h11);
    chk("R4 concurrent phase", {7'd0, data_phase}, 8'd0);
    get(8'h04, g); chk("R4 concurrent write landed", g, 8'h77);
  endtask

  task automatic t_flag();
    logic [7:0] g;
    put(8'h05, 8'h21);
    to_index();
    do_wr(8'h25);
    chk("R6 flag set", {7'd0, flag_out}, 8'd1);
    do_rd(0, 1, 0, 8'h00, g);
    chk("R6 aliases reg 5", g, 8'h21);
    do_wr(8'h6E);
    get(8'hC5, g); chk("R6 upper bits ignored", g, 8'h6E);
    chk("R6 flag clear", {7'd0, flag_out}, 8'd0);
  endtask

  task automatic t_oob();
    logic [7:0] g;
    put(8'h15, 8'hEE);
    get(8'h15, g); chk("R7 index 21 reads zero", g, 8'h00);
    put(8'h1F, 8'hDD);
    get(8'h1F, g); chk("R7 index 31 reads zero", g, 8'h00);
    get(8'h14, g); chk("R7 last reg intact", g, 8'h5A);
    get(8'h00, g); chk("R7 reg 0 intact", g, 8'hFF);
  endtask

  task automatic t_priority();
    logic [7:0] g;
    to_index();
    do_wr(8'h03);
    do_rd(1, 1, 1, 8'h42, g);
    chk("R8 status wins", g, 8'h42);
    to_index();
    do_wr(8'h03);
    do_rd(1, 1, 0, 8'h00, g);
    chk("R8 data over index", g, exp_reg());
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_pairs();
    t_index_read();
    t_status();
    t_flag();
    t_oob();
    t_priority();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule